// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

This block stands between a processor's data path and a 32-bit bus controller. It takes one operand request at a time. A request carries a byte address, an operand size (byte, word or long word), a read/write flag, right-justified write data and a cachable flag. A non-cachable operand that is not on its natural boundary is broken into a run of naturally aligned bus transfers. The transfers are issued lowest address first, and each waits for the bus handshake of the one before it. For reads, the returned byte lanes are gathered into one right-justified result. That result comes with a single completion pulse.

Cachable requests are forwarded as one unchanged transfer, because the line fill path deals with their alignment. Data operands never raise an error, whatever their address. A separate instruction-fetch port works without any clock. It forwards fetches at even addresses and flags an address error for an odd one, with no bus request.

Top module: `opnd_splitter`

## Requirements
- R1: Size codes on req_size and bus_size are 0 = byte, 1 = word, 2 = long word (3 is treated as a long word). A byte at any address, a word at an even address, and a long word at an address that is a multiple of four are each sent as exactly one transfer with the request's own address and size.
- R2: A non-cachable misaligned operand is split into transfers that are each aligned. Each transfer is the largest aligned size that fits the remaining bytes. A long word at offset 1 or 3 gives byte, word, byte. At offset 2 it gives word, word. A word at an odd address gives byte, byte.
- R3: Sub-transfers go out in ascending address order. bus_valid stays high and bus_addr, bus_size and bus_wdata hold steady while bus_ready is low. The next piece appears only after a cycle in which bus_valid and bus_ready are both high.
- R4: Byte lanes are big-endian. Lane k (bus_wdata[31-8k -: 8]) carries the byte whose address modulo 4 is k. The most significant byte of the right-justified operand is at the lowest address. A write piece drives only the lanes it covers and drives all other lanes to zero. A read drives bus_wdata to zero.
- R5: Exactly one done pulse, one cycle long, follows the clock edge of the last handshake. For a read, done_rdata then holds the operand right-justified with its upper bytes zero. For a write, done_rdata is zero.
- R6: A cachable request, aligned or not, is sent as one transfer with the original address, size and write data, and with bus_cache high. Its done_rdata is the raw 32-bit bus_rdata.
- R7: An odd fetch_addr with fetch_valid raises fetch_err and keeps fetch_bus_valid low. An even one raises fetch_bus_valid with fetch_bus_addr equal to fetch_addr and no error. Both happen in the same cycle, with no clock involved.
- R8: req_ready is high after reset. It goes low from the cycle after a request is accepted until the done cycle. It is high again in the done cycle, so a new request can be accepted then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Right-justified write operand |
| req_cache | input | 1 | Request is cachable |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Right-justified read result |
| bus_valid | output | 1 | Bus transfer present |
| bus_ready | input | 1 | Bus accepts the transfer |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | DATA_W | Lane-placed write data |
| bus_cache | output | 1 | Transfer is a cachable pass-through |
| bus_rdata | input | DATA_W | Lane data returned with bus_ready |
| fetch_valid | input | 1 | Instruction fetch present |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_bus_valid | output | 1 | Fetch forwarded to the bus |
| fetch_bus_addr | output | ADDR_W | Forwarded fetch address |
| fetch_err | output | 1 | Address error on an odd fetch |

## Verification
The done pulse that ends one split sequence and the acceptance of the next request can happen in the same cycle. The bench watches for the done cycle of a three-piece long-word read. In that cycle it presents a new misaligned word read, then checks that req_ready is high there. It also checks that both results come back correct and that exactly five transfers are seen, with no piece lost or duplicated at the boundary. A second overlap is a fetch check made while a split sequence is running on the data side.

// File: rtl/opnd_split_pkg.sv
package opnd_split_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } opsz_e;

   // byte count minus one for a size code
   function automatic logic [1:0] size_last(input logic [1:0] code);
      case (code)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/opnd_piece_pick.sv
module opnd_piece_pick
   import opnd_split_pkg::*;
(
   input  logic [1:0] lo_addr,
   input  logic [2:0] remain,
   output opsz_e      piece_sz,
   output logic [2:0] piece_len
);
   always_comb begin
      if (remain >= 3'd4 && lo_addr == 2'd0) begin
         piece_sz  = SZ_LONG;
         piece_len = 3'd4;
      end else if (remain >= 3'd2 && !lo_addr[0]) begin
         piece_sz  = SZ_WORD;
         piece_len = 3'd2;
      end else begin
         piece_sz  = SZ_BYTE;
         piece_len = 3'd1;
      end
   end
endmodule

// File: rtl/opnd_lane_steer.sv
module opnd_lane_steer #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        lane_start,
   input  logic [2:0]        piece_len,
   input  logic [1:0]        consumed,
   input  logic [1:0]        op_last,
   input  logic [DATA_W-1:0] op_wdata,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] acc_in,
   output logic [DATA_W-1:0] lane_wdata,
   output logic [DATA_W-1:0] acc_out
);
   localparam int LANES = DATA_W / 8;

   logic [LANES-1:0] cov;
   logic [1:0]       pos [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [2:0] LN = 3'(l);
      logic [2:0] hi;
      logic [1:0] idx;
      always_comb begin
         hi     = {1'b0, lane_start} + piece_len;
         cov[l] = (LN >= {1'b0, lane_start}) && (LN < hi);
         idx    = consumed + (LN[1:0] - lane_start);
         pos[l] = op_last - idx;
         lane_wdata[DATA_W-1-8*l -: 8] = cov[l] ? op_wdata[8*pos[l] +: 8] : 8'h00;
      end
   end

   always_comb begin
      acc_out = acc_in;
      for (int l = 0; l < LANES; l++) begin
         if (cov[l]) acc_out[8*pos[l] +: 8] = rdata[DATA_W-1-8*l -: 8];
      end
   end
endmodule

// File: rtl/opnd_fetch_check.sv
module opnd_fetch_check #(
   parameter int ADDR_W = 32
) (
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_bus_valid,
   output logic [ADDR_W-1:0] fetch_bus_addr,
   output logic              fetch_err
);
   always_comb begin
      fetch_err       = fetch_valid & fetch_addr[0];
      fetch_bus_valid = fetch_valid & ~fetch_addr[0];
      fetch_bus_addr  = fetch_addr;
   end
endmodule

// File: rtl/opnd_splitter.sv
module opnd_splitter
   import opnd_split_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_cache,
   output logic              done,
   output logic [DATA_W-1:0] done_rdata,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic              bus_write,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_cache,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_bus_valid,
   output logic [ADDR_W-1:0] fetch_bus_addr,
   output logic              fetch_err
);
   if (DATA_W != 32) begin : g_bad_data_w
      $error("opnd_splitter: DATA_W must be 32");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("opnd_splitter: ADDR_W must be at least 3");
   end

   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        size_q;
   logic [1:0]        last_q;
   logic [2:0]        rem_q;
   logic [1:0]        cons_q;
   logic              write_q;
   logic              cache_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] acc_q;

   opsz_e             p_sz;
   logic [2:0]        p_len;
   logic [DATA_W-1:0] lane_w;
   logic [DATA_W-1:0] acc_nx;
   logic              final_piece;

   opnd_piece_pick u_pick (
      .lo_addr   (addr_q[1:0]),
      .remain    (rem_q),
      .piece_sz  (p_sz),
      .piece_len (p_len)
   );

   opnd_lane_steer #(.DATA_W(DATA_W)) u_steer (
      .lane_start (addr_q[1:0]),
      .piece_len  (p_len),
      .consumed   (cons_q),
      .op_last    (last_q),
      .op_wdata   (wdata_q),
      .rdata      (bus_rdata),
      .acc_in     (acc_q),
      .lane_wdata (lane_w),
      .acc_out    (acc_nx)
   );

   opnd_fetch_check #(.ADDR_W(ADDR_W)) u_fetch (
      .fetch_valid     (fetch_valid),
      .fetch_addr      (fetch_addr),
      .fetch_bus_valid (fetch_bus_valid),
      .fetch_bus_addr  (fetch_bus_addr),
      .fetch_err       (fetch_err)
   );

   assign final_piece = cache_q || (rem_q == p_len);
   assign req_ready   = ~busy_q;
   assign bus_valid   = busy_q;
   assign bus_addr    = addr_q;
   assign bus_size    = cache_q ? size_q : p_sz;
   assign bus_write   = write_q;
   assign bus_cache   = cache_q;
   assign bus_wdata   = !write_q ? '0 : (cache_q ? wdata_q : lane_w);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         addr_q     <= '0;
         size_q     <= 2'd0;
         last_q     <= 2'd0;
         rem_q      <= 3'd0;
         cons_q     <= 2'd0;
         write_q    <= 1'b0;
         cache_q    <= 1'b0;
         wdata_q    <= '0;
         acc_q      <= '0;
         done       <= 1'b0;
         done_rdata <= '0;
      end else begin
         done <= 1'b0;
         if (!busy_q && req_valid) begin
            busy_q  <= 1'b1;
            addr_q  <= req_addr;
            size_q  <= req_size;
            last_q  <= size_last(req_size);
            rem_q   <= {1'b0, size_last(req_size)} + 3'd1;
            cons_q  <= 2'd0;
            write_q <= req_write;
            cache_q <= req_cache;
            wdata_q <= req_wdata;
            acc_q   <= '0;
         end else if (busy_q && bus_ready) begin
            if (final_piece) begin
               busy_q     <= 1'b0;
               done       <= 1'b1;
               done_rdata <= write_q ? '0 : (cache_q ? bus_rdata : acc_nx);
            end else begin
               addr_q <= addr_q + ADDR_W'(p_len);
               rem_q  <= rem_q - p_len;
               cons_q <= cons_q + p_len[1:0];
               acc_q  <= acc_nx;
            end
         end
      end
   end
endmodule

// File: rtl/opnd_split_chk.sv
module opnd_split_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_cache,
   input logic              fetch_valid,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              fetch_bus_valid,
   input logic              fetch_err
);
   AST_PIECE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_cache |-> (bus_size == 2'd0) || (bus_size == 2'd1 && !bus_addr[0])
                                  || (bus_size == 2'd2 && bus_addr[1:0] == 2'd0)); // R2
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_size)
                                  && $stable(bus_wdata)); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !req_ready); // R8
   AST_ODD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid && fetch_addr[0] |-> fetch_err && !fetch_bus_valid); // R7
   AST_EVEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid && !fetch_addr[0] |-> fetch_bus_valid && !fetch_err); // R7
endmodule

bind opnd_splitter opnd_split_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_ready       (req_ready),
   .done            (done),
   .bus_valid       (bus_valid),
   .bus_ready       (bus_ready),
   .bus_addr        (bus_addr),
   .bus_size        (bus_size),
   .bus_wdata       (bus_wdata),
   .bus_cache       (bus_cache),
   .fetch_valid     (fetch_valid),
   .fetch_addr      (fetch_addr),
   .fetch_bus_valid (fetch_bus_valid),
   .fetch_err       (fetch_err)
);

// File: tb/opnd_splitter_bench.sv
`timescale 1ns/1ps
module opnd_splitter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = 2'd0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        req_cache = 1'b0;
   logic        done;
   logic [31:0] done_rdata;
   logic        bus_valid;
   logic        bus_ready = 1'b1;
   logic [31:0] bus_addr;
   logic [1:0]  bus_size;
   logic        bus_write;
   logic [31:0] bus_wdata;
   logic        bus_cache;
   logic [31:0] bus_rdata;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_bus_valid;
   logic [31:0] fetch_bus_addr;
   logic        fetch_err;

   int checks = 0;
   int errors = 0;
   bit stall = 0;
   int lg_n = 0;
   logic [31:0] lg_addr [8];
   logic [1:0]  lg_size [8];
   logic [31:0] lg_wdata [8];
   logic        lg_cache [8];
   int dn_n = 0;
   logic [31:0] dn_val;

   always #2.5 clk = ~clk;

   opnd_splitter u_opnd_splitter (.*);

   function automatic logic [7:0] mb(input logic [31:0] x);
      return x[7:0] ^ 8'h5A ^ {x[11:8], 4'h0};
   endfunction

   always_comb begin
      bus_rdata = {mb({bus_addr[31:2], 2'd0}), mb({bus_addr[31:2], 2'd1}),
                   mb({bus_addr[31:2], 2'd2}), mb({bus_addr[31:2], 2'd3})};
   end

   always @(negedge clk) begin
      if (stall) bus_ready = ~bus_ready;
      else bus_ready = 1'b1;
      if (bus_valid && bus_ready && lg_n < 8) begin
         lg_addr[lg_n]  = bus_addr;
         lg_size[lg_n]  = bus_size;
         lg_wdata[lg_n] = bus_wdata;
         lg_cache[lg_n] = bus_cache;
         lg_n++;
      end
      if (done) begin
         dn_n++;
         dn_val = done_rdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_req(input logic [31:0] addr, input logic [1:0] sz, input bit wr,
                          input logic [31:0] wd, input bit cache, input bit stl, input string tag);
      int n, ne, r, s;
      logic [31:0] a, w, er;
      logic [31:0] ea [8];
      logic [1:0]  es [8];
      logic [31:0] ew [8];
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      ne = 0;
      if (cache) begin
         ea[0] = addr; es[0] = sz; ew[0] = wr ? wd : 32'h0; ne = 1;
         er = wr ? 32'h0 : {mb({addr[31:2], 2'd0}), mb({addr[31:2], 2'd1}),
                             mb({addr[31:2], 2'd2}), mb({addr[31:2], 2'd3})};
      end else begin
         a = addr; r = n;
         while (r > 0) begin
            s = (r >= 4 && a[1:0] == 2'd0) ? 4 : (r >= 2 && !a[0]) ? 2 : 1;
            w = '0;
            for (int x = 0; x < s; x++) begin
               int lane, idx;
               lane = int'(a[1:0]) + x;
               idx  = int'(a - addr) + x;
               w[31-8*lane -: 8] = wd[8*(n-1-idx) +: 8];
            end
            ea[ne] = a; es[ne] = (s == 4) ? 2'd2 : (s == 2) ? 2'd1 : 2'd0;
            ew[ne] = wr ? w : 32'h0;
            a = a + 32'(s); r = r - s; ne++;
         end
         er = '0;
         if (!wr) for (int i = 0; i < n; i++) er[8*(n-1-i) +: 8] = mb(addr + 32'(i));
      end
      stall = stl;
      req_addr = addr; req_size = sz; req_write = wr; req_wdata = wd; req_cache = cache;
      req_valid = 1'b1;
      lg_n = 0; dn_n = 0;
      chk(req_ready == 1'b1, {tag, " R8 ready before accept"}, 32'(req_ready), 32'd1);
      @(posedge clk);
      @(negedge clk); #1;
      req_valid = 1'b0;
      chk(req_ready == 1'b0, {tag, " R8 ready low while busy"}, 32'(req_ready), 32'd0);
      for (int k = 0; k < 60 && dn_n == 0; k++) begin
         @(negedge clk); #1;
      end
      @(negedge clk); #1;
      stall = 0;
      chk(dn_n == 1, {tag, " R5 one done pulse"}, 32'(dn_n), 32'd1);
      chk(lg_n == ne, {tag, " R1 R2 transfer count"}, 32'(lg_n), 32'(ne));
      for (int i = 0; i < ne && i < lg_n; i++) begin
         chk(lg_addr[i] == ea[i], {tag, " R3 piece address"}, lg_addr[i], ea[i]);
         chk(lg_size[i] == es[i], {tag, " R2 piece size"}, 32'(lg_size[i]), 32'(es[i]));
         chk(lg_wdata[i] == ew[i], {tag, " R4 piece lanes"}, lg_wdata[i], ew[i]);
         chk(lg_cache[i] == cache, {tag, " R6 cache flag"}, 32'(lg_cache[i]), 32'(cache));
      end
      chk(dn_val == er, {tag, " R5 done data"}, dn_val, er);
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R8 reset ready", 32'(req_ready), 32'd1);
      chk(bus_valid == 1'b0, "R3 reset bus idle", 32'(bus_valid), 32'd0);
      chk(done == 1'b0, "R5 reset done low", 32'(done), 32'd0);
   endtask

   task automatic t_aligned;
      run_req(32'h100, 2'd2, 0, 32'h0, 0, 0, "R1 long aligned read");
      run_req(32'h103, 2'd0, 0, 32'h0, 0, 0, "R1 byte odd read");
      run_req(32'h10E, 2'd1, 1, 32'h0000BEEF, 0, 0, "R1 word even write");
   endtask

   task automatic t_split_reads;
      run_req(32'h201, 2'd1, 0, 32'h0, 0, 0, "R2 word odd read");
      run_req(32'h301, 2'd2, 0, 32'h0, 0, 0, "R2 long off1 read");
      run_req(32'h402, 2'd2, 0, 32'h0, 0, 0, "R2 long off2 read");
      run_req(32'h503, 2'd2, 0, 32'h0, 0, 1, "R3 long off3 read stalled");
   endtask

   task automatic t_split_writes;
      run_req(32'h601, 2'd2, 1, 32'h11223344, 0, 0, "R4 long off1 write");
      run_req(32'h707, 2'd1, 1, 32'h0000A1B2, 0, 1, "R4 word odd write stalled");
      run_req(32'h60B, 2'd2, 1, 32'hCAFEF00D, 0, 0, "R4 long off3 write");
   endtask

   task automatic t_cache;
      run_req(32'h805, 2'd2, 0, 32'h0, 1, 0, "R6 cachable misaligned read");
      run_req(32'h807, 2'd1, 1, 32'h00005566, 1, 0, "R6 cachable odd write");
   endtask

   task automatic t_fetch;
      fetch_valid = 1'b1; fetch_addr = 32'h1235; #1;
      chk(fetch_err == 1'b1 && fetch_bus_valid == 1'b0, "R7 odd fetch error",
          {30'd0, fetch_err, fetch_bus_valid}, 32'h2);
      fetch_addr = 32'h1236; #1;
      chk(fetch_err == 1'b0 && fetch_bus_valid == 1'b1 && fetch_bus_addr == 32'h1236,
          "R7 even fetch forwarded", fetch_bus_addr, 32'h1236);
      fetch_valid = 1'b0;
   endtask

   task automatic t_back_to_back;
      logic [31:0] first_val, exp_a, exp_b;
      exp_a = {mb(32'h901), mb(32'h902), mb(32'h903), mb(32'h904)};
      exp_b = {16'h0, mb(32'hA03), mb(32'hA04)};
      req_addr = 32'h901; req_size = 2'd2; req_write = 0; req_wdata = '0; req_cache = 0;
      req_valid = 1'b1; lg_n = 0;
      @(posedge clk); @(negedge clk); #1;
      req_valid = 1'b0;
      // fetch check while a split sequence runs
      fetch_valid = 1'b1; fetch_addr = 32'h2001; #1;
      chk(fetch_err == 1'b1 && bus_valid == 1'b1, "R7 fetch error during split",
          {30'd0, fetch_err, bus_valid}, 32'h3);
      fetch_valid = 1'b0;
      for (int k = 0; k < 40 && done == 1'b0; k++) begin
         @(negedge clk); #1;
      end
      first_val = done_rdata;
      chk(req_ready == 1'b1, "R8 ready in done cycle", 32'(req_ready), 32'd1);
      chk(first_val == exp_a, "R5 first result back to back", first_val, exp_a);
      req_addr = 32'hA03; req_size = 2'd1; req_valid = 1'b1;
      @(posedge clk); @(negedge clk); #1;
      req_valid = 1'b0;
      for (int k = 0; k < 40 && done == 1'b0; k++) begin
         @(negedge clk); #1;
      end
      chk(done_rdata == exp_b, "R5 second result back to back", done_rdata, exp_b);
      @(negedge clk); #1;
      chk(lg_n == 5, "R2 transfers across back to back", 32'(lg_n), 32'd5);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #1;
      t_reset();
      t_aligned();
      t_split_reads();
      t_split_writes();
      t_cache();
      t_fetch();
      t_back_to_back();
      repeat (3) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule